// File: doc/BRIEF.md
# Interleaved Configuration Stream Section Finder

The block sits on a byte stream that carries several configuration images woven together in fixed-size chunks: a run of `CHUNK` bytes of image 1, then a run of image 2, and so on. This repeats over the image count. After a `start` pulse it counts raw bytes and keeps only the chunks of the image chosen by `sel_idx`. Every byte of the other images is accepted and thrown away.

The kept bytes must open with a fixed 13-byte preamble. After the preamble comes a chain of tagged sections. Each section is a one-byte letter, then a big-endian length, then that many content bytes. The block walks this chain until it meets the letter given on `want_tag`. It then raises `found`, reports the section's length on `sect_len` and from then on hands every kept byte through to the output port. If the stream is malformed or the letter is never reached, the walk ends in a terminal failure with a reason code.

Top module: `ilv_section_finder`

## Requirements
- R1: Raw byte n, counting the accepted input bytes from 0 after the last `start`, belongs to the selected image when floor(n / CHUNK) mod `img_cnt` equals `sel_idx` − 1. Only such bytes reach the parser. A new `start` clears the count, the status and the length.
- R2: A byte of another image is always accepted (`in_ready` high) once a run is under way. It never changes the parse, and it is never presented on the output port.
- R3: The first 13 kept bytes must be 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. The first byte that differs ends the run with `fail` high and `fail_code` = 1.
- R4: The section tag 0x65 ('e') is followed by a 4-byte big-endian length. Every other legal tag is followed by a 2-byte big-endian length.
- R5: A tag byte outside 0x61..0x65 ('a'..'e') ends the run with `fail_code` = 2.
- R6: A section whose tag is not 'e' and whose length is above 255 ends the run with `fail_code` = 3.
- R7: The block counts the kept bytes after the preamble (tags, length bytes and skipped content). When that count reaches 100 and no match has been made, the run ends with `fail_code` = 4.
- R8: When the tag of a section equals `want_tag`, `found` rises and `sect_len` shows its length. Both are registered and visible in the cycle after the last length byte is accepted. They hold until the next `start`, and `found` and `fail` are never high together.
- R9: While `found` is high, each kept byte appears on `out_data` with `out_valid` in the cycle it is offered. A kept byte is accepted only when `out_ready` is high.
- R10: After reset and before the first `start`, `found`, `fail` and `fail_code` are 0 and `in_ready` is low. `in_ready` is also low in a cycle where `start` is high.
- R11: A failure is terminal until the next `start`. `fail` and `fail_code` hold, and every input byte is accepted and dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a new run; clears counters and status |
| sel_idx | input | IMG_W | Selected image number, counted from 1 |
| img_cnt | input | IMG_W | Number of interleaved images |
| want_tag | input | 8 | Section letter to look for |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted this cycle when valid |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_ready | input | 1 | Downstream takes the forwarded byte |
| found | output | 1 | Requested section reached |
| fail | output | 1 | Run ended without a match |
| fail_code | output | 3 | 1 preamble, 2 bad tag, 3 oversize length, 4 search limit |
| sect_len | output | 32 | Length of the matched section |

## Verification
The forwarding path is combinational, so `in_ready`, `out_valid` and `out_data` are due in the same cycle an input byte is offered. The bench drives each byte on the falling edge and samples these outputs a moment later, before the rising edge that commits the transfer. The status outputs pass through one register, so `found` and `sect_len` are due in the cycle after the final length byte is accepted. On every falling edge the bench compares `found` against the number of selected-image bytes it has handed over, which pins that single-cycle delay. A failure reason is checked once the run has stopped, and the draining behaviour is checked one byte later.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   localparam int PRE_LEN = 13;

   localparam logic [7:0] TAG_FIRST = 8'h61;
   localparam logic [7:0] TAG_LAST  = 8'h65;
   localparam logic [7:0] TAG_WIDE  = 8'h65;

   typedef enum logic [2:0] {
      FC_NONE     = 3'd0,
      FC_PREAMBLE = 3'd1,
      FC_BAD_TAG  = 3'd2,
      FC_BIG_LEN  = 3'd3,
      FC_LIMIT    = 3'd4
   } fail_e;

   typedef enum logic [2:0] {
      W_IDLE = 3'd0,
      W_PRE  = 3'd1,
      W_TAG  = 3'd2,
      W_LEN  = 3'd3,
      W_SKIP = 3'd4,
      W_FWD  = 3'd5,
      W_FAIL = 3'd6
   } wstate_e;

   function automatic logic [7:0] preamble_byte(input logic [3:0] pos);
      logic [7:0] b;
      case (pos)
         4'd1:                    b = 8'h09;
         4'd2, 4'd4, 4'd6, 4'd8:  b = 8'h0F;
         4'd3, 4'd5, 4'd7, 4'd9:  b = 8'hF0;
         4'd12:                   b = 8'h01;
         default:                 b = 8'h00;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/ilv_chunk_track.sv
module ilv_chunk_track #(
   parameter int CHUNK = 288,
   parameter int IMG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   input  logic [IMG_W-1:0] sel_idx,
   input  logic [IMG_W-1:0] img_cnt,
   output logic             keep
);

   localparam int  OFS_W    = (CHUNK > 1) ? $clog2(CHUNK) : 1;
   localparam bit  IS_POW2  = (CHUNK & (CHUNK - 1)) == 0;

   logic             wrap;
   logic [IMG_W-1:0] idx;
   logic [IMG_W:0]   idx_inc;

   if (CHUNK < 2) begin : g_bad_chunk
      $error("ilv_chunk_track: CHUNK must be at least 2");
   end

   if (IS_POW2) begin : g_pow2
      logic [OFS_W-1:0] ofs;
      assign wrap = &ofs;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ofs <= '0;
         else if (clear)  ofs <= '0;
         else if (step)   ofs <= ofs + 1'b1;
      end
   end else begin : g_any
      logic [OFS_W-1:0] ofs;
      assign wrap = (ofs == OFS_W'(CHUNK - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ofs <= '0;
         else if (clear)  ofs <= '0;
         else if (step)   ofs <= wrap ? '0 : ofs + 1'b1;
      end
   end

   assign idx_inc = {1'b0, idx} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
      end else if (clear) begin
         idx <= '0;
      end else if (step && wrap) begin
         if (idx_inc >= {1'b0, img_cnt}) idx <= '0;
         else                            idx <= idx_inc[IMG_W-1:0];
      end
   end

   assign keep = (idx_inc == {1'b0, sel_idx});

endmodule

// File: rtl/ilv_preamble_match.sv
module ilv_preamble_match
   import ilv_pkg::*;
(
   input  logic [3:0] pos,
   input  logic [7:0] byte_i,
   output logic       ok
);

   assign ok = (byte_i == preamble_byte(pos));

endmodule

// File: rtl/ilv_sect_walker.sv
module ilv_sect_walker
   import ilv_pkg::*;
#(
   parameter int LIMIT = 100,
   parameter int LEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             take,
   input  logic [7:0]       byte_i,
   input  logic [7:0]       want_tag,
   input  logic             pre_ok,
   output logic [3:0]       pre_pos,
   output wstate_e          st,
   output fail_e            code,
   output logic [LEN_W-1:0] len_o
);

   localparam int CNT_W = $clog2(LIMIT + 8);

   if (LEN_W < 32) begin : g_bad_len
      $error("ilv_sect_walker: LEN_W must hold a four-byte length");
   end
   if (LIMIT < 1) begin : g_bad_limit
      $error("ilv_sect_walker: LIMIT must be positive");
   end

   logic [CNT_W-1:0] hdr_cnt;
   logic [CNT_W-1:0] hdr_n;
   logic [LEN_W-1:0] acc;
   logic [LEN_W-1:0] acc_n;
   logic [1:0]       len_left;
   logic [7:0]       cur_tag;
   logic             tag_ok;
   logic             at_limit;
   logic             wide;

   always_comb begin
      hdr_n    = hdr_cnt + 1'b1;
      acc_n    = {acc[LEN_W-9:0], byte_i};
      tag_ok   = (byte_i >= TAG_FIRST) && (byte_i <= TAG_LAST);
      at_limit = (hdr_n >= CNT_W'(LIMIT));
      wide     = (cur_tag == TAG_WIDE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= W_IDLE;
         code     <= FC_NONE;
         pre_pos  <= '0;
         hdr_cnt  <= '0;
         acc      <= '0;
         len_left <= '0;
         cur_tag  <= '0;
         len_o    <= '0;
      end else if (start) begin
         st       <= W_PRE;
         code     <= FC_NONE;
         pre_pos  <= '0;
         hdr_cnt  <= '0;
         acc      <= '0;
         len_left <= '0;
         cur_tag  <= '0;
         len_o    <= '0;
      end else if (take) begin
         case (st)
            W_PRE: begin
               if (!pre_ok) begin
                  st   <= W_FAIL;
                  code <= FC_PREAMBLE;
               end else if (pre_pos == 4'(PRE_LEN - 1)) begin
                  st <= W_TAG;
               end else begin
                  pre_pos <= pre_pos + 1'b1;
               end
            end
            W_TAG: begin
               hdr_cnt <= hdr_n;
               if (!tag_ok) begin
                  st   <= W_FAIL;
                  code <= FC_BAD_TAG;
               end else begin
                  cur_tag  <= byte_i;
                  len_left <= (byte_i == TAG_WIDE) ? 2'd3 : 2'd1;
                  acc      <= '0;
                  st       <= W_LEN;
               end
            end
            W_LEN: begin
               hdr_cnt <= hdr_n;
               acc     <= acc_n;
               if (len_left != 2'd0) begin
                  len_left <= len_left - 1'b1;
               end else if (!wide && (acc_n > LEN_W'(255))) begin
                  st   <= W_FAIL;
                  code <= FC_BIG_LEN;
               end else if (cur_tag == want_tag) begin
                  st    <= W_FWD;
                  len_o <= acc_n;
               end else if (at_limit) begin
                  st   <= W_FAIL;
                  code <= FC_LIMIT;
               end else if (acc_n == '0) begin
                  st <= W_TAG;
               end else begin
                  st <= W_SKIP;
               end
            end
            W_SKIP: begin
               hdr_cnt <= hdr_n;
               acc     <= acc - LEN_W'(1);
               if (at_limit) begin
                  st   <= W_FAIL;
                  code <= FC_LIMIT;
               end else if (acc == LEN_W'(1)) begin
                  st <= W_TAG;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/ilv_section_finder.sv
module ilv_section_finder
   import ilv_pkg::*;
#(
   parameter int CHUNK = 288,
   parameter int IMG_W = 4,
   parameter int LIMIT = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IMG_W-1:0] sel_idx,
   input  logic [IMG_W-1:0] img_cnt,
   input  logic [7:0]       want_tag,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             out_valid,
   output logic [7:0]       out_data,
   input  logic             out_ready,
   output logic             found,
   output logic             fail,
   output logic [2:0]       fail_code,
   output logic [31:0]      sect_len
);

   localparam int LEN_W = 32;

   if (IMG_W < 1) begin : g_bad_img
      $error("ilv_section_finder: IMG_W must be positive");
   end

   logic       keep;
   logic       accept;
   logic       take;
   logic       pre_ok;
   logic [3:0] pre_pos;
   logic       walk_idle;
   logic       fwd_kept;
   wstate_e    st;
   fail_e      code;

   ilv_chunk_track #(
      .CHUNK (CHUNK),
      .IMG_W (IMG_W)
   ) u_chunk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start),
      .step    (accept),
      .sel_idx (sel_idx),
      .img_cnt (img_cnt),
      .keep    (keep)
   );

   ilv_preamble_match u_pre (
      .pos    (pre_pos),
      .byte_i (in_data),
      .ok     (pre_ok)
   );

   ilv_sect_walker #(
      .LIMIT (LIMIT),
      .LEN_W (LEN_W)
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .take     (take),
      .byte_i   (in_data),
      .want_tag (want_tag),
      .pre_ok   (pre_ok),
      .pre_pos  (pre_pos),
      .st       (st),
      .code     (code),
      .len_o    (sect_len)
   );

   assign walk_idle = (st == W_IDLE);
   assign fwd_kept  = keep && (st == W_FWD);

   always_comb begin
      if (start || walk_idle) in_ready = 1'b0;
      else if (fwd_kept)      in_ready = out_ready;
      else                    in_ready = 1'b1;
   end

   assign accept    = in_valid && in_ready;
   assign take      = accept && keep && (st != W_FWD) && (st != W_FAIL);
   assign out_valid = in_valid && fwd_kept && !start;
   assign out_data  = in_data;
   assign found     = (st == W_FWD);
   assign fail      = (st == W_FAIL);
   assign fail_code = code;

endmodule

// File: rtl/ilv_checker.sv
module ilv_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic        found,
   input logic        fail,
   input logic [2:0]  fail_code,
   input logic [31:0] sect_len,
   input logic        walk_idle
);

   AST_FOUND_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(found && fail)); // R8

   AST_FOUND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      found && !start |=> found && $stable(sect_len)); // R8

   AST_FWD_NEEDS_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> found); // R9

   AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fail && !start |=> fail && $stable(fail_code)); // R11

   AST_FAIL_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      fail && !start |-> in_ready); // R11

   AST_FAIL_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> fail_code != 3'd0); // R3

   AST_STALL_ONLY_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_ready && !start && !walk_idle |-> out_valid && !out_ready); // R2

   AST_IDLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      walk_idle |-> !in_ready && !found && !fail); // R10

   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !found && !fail && fail_code == 3'd0); // R1

endmodule

bind ilv_section_finder ilv_checker u_ilv_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .found     (found),
   .fail      (fail),
   .fail_code (fail_code),
   .sect_len  (sect_len),
   .walk_idle (walk_idle)
);

// File: tb/test_ilv_section_finder.sv
module test_ilv_section_finder;

   localparam int CH      = 20;
   localparam int IMG_W   = 4;
   localparam int IMG_MAX = 160;

   // {sel[3:0], n[3:0], tag[7:0], scen[3:0], code[2:0], len[31:0]}
   localparam logic [54:0] VECS [9] = '{
      {4'd1, 4'd1, 8'h65, 4'd0, 3'd0, 32'h0001_2345},
      {4'd2, 4'd3, 8'h65, 4'd0, 3'd0, 32'h0001_2345},
      {4'd3, 4'd3, 8'h62, 4'd0, 3'd0, 32'd9},
      {4'd1, 4'd2, 8'h63, 4'd0, 3'd0, 32'd1},
      {4'd2, 4'd2, 8'h61, 4'd1, 3'd1, 32'd0},
      {4'd1, 4'd3, 8'h65, 4'd2, 3'd2, 32'd0},
      {4'd2, 4'd2, 8'h65, 4'd3, 3'd3, 32'd0},
      {4'd3, 4'd4, 8'h65, 4'd4, 3'd4, 32'd0},
      {4'd1, 4'd2, 8'h62, 4'd4, 3'd0, 32'd50}
   };

   localparam logic [7:0] PRE [13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
                                       8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [IMG_W-1:0] sel_idx = '0;
   logic [IMG_W-1:0] img_cnt = '0;
   logic [7:0]       want_tag = '0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = '0;
   logic             in_ready;
   logic             out_valid;
   logic [7:0]       out_data;
   logic             out_ready = 1'b1;
   logic             found;
   logic             fail;
   logic [2:0]       fail_code;
   logic [31:0]      sect_len;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [7:0] img [IMG_MAX];
   int wp;
   int pay_start;
   int p;
   int ptr;
   int fwd;
   bit lat_bad;
   bit fwd_bad;

   always #2 clk = ~clk;

   ilv_section_finder #(.CHUNK(CH), .IMG_W(IMG_W), .LIMIT(100)) i_ilv_section_finder (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .sel_idx   (sel_idx),
      .img_cnt   (img_cnt),
      .want_tag  (want_tag),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_ready (out_ready),
      .found     (found),
      .fail      (fail),
      .fail_code (fail_code),
      .sect_len  (sect_len)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      if (wp < IMG_MAX) img[wp] = b;
      wp++;
   endtask

   task automatic sec(input logic [7:0] t, input int len, input logic [7:0] base, input logic [7:0] want);
      logic [31:0] l;
      int cnt;
      l = 32'(len);
      put(t);
      if (t == 8'h65) begin
         put(l[31:24]);
         put(l[23:16]);
      end
      put(l[15:8]);
      put(l[7:0]);
      if (t == want && pay_start < 0) pay_start = wp;
      cnt = (len > 60) ? 20 : len;
      for (int i = 0; i < cnt; i++) put(8'(base + 8'(i)));
   endtask

   task automatic build(input int scen, input logic [7:0] want);
      for (int i = 0; i < IMG_MAX; i++) img[i] = 8'(8'h80 + i);
      wp = 0;
      pay_start = -1;
      for (int i = 0; i < 13; i++) put(PRE[i]);
      case (scen)
         0, 1: begin
            sec(8'h61, 2, 8'h11, want);
            sec(8'h62, 9, 8'h20, want);
            sec(8'h63, 1, 8'h30, want);
            sec(8'h64, 3, 8'h40, want);
            sec(8'h65, 32'h0001_2345, 8'h50, want);
         end
         2: begin
            sec(8'h61, 2, 8'h11, want);
            put(8'h67);
         end
         3: begin
            sec(8'h61, 2, 8'h11, want);
            sec(8'h63, 256, 8'h30, want);
         end
         default: begin
            sec(8'h61, 50, 8'h01, want);
            sec(8'h62, 50, 8'h40, want);
            sec(8'h65, 4, 8'h70, want);
         end
      endcase
      if (scen == 1) img[5] = 8'h0E;
   endtask

   task automatic pulse_start(input int sel, input int n, input logic [7:0] tag);
      @(negedge clk);
      sel_idx  = IMG_W'(sel);
      img_cnt  = IMG_W'(n);
      want_tag = tag;
      in_valid = 1'b0;
      start    = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Feeds the interleaved stream; stops at failure, at found with max_fwd bytes forwarded,
   // or when the image runs out. Leaves the bench at a falling edge with in_valid low.
   task automatic run_stream(input int sel, input int n, input bit exp_ok, input int max_fwd);
      bit kept;
      bit acc;
      p = 0;
      ptr = 0;
      fwd = 0;
      lat_bad = 0;
      fwd_bad = 0;
      for (int g = 0; g < 4000; g++) begin
         if (g > 0) @(negedge clk);
         in_valid = 1'b0;
         if (exp_ok && (found != (ptr >= pay_start))) lat_bad = 1;
         if (fail || (found && fwd >= max_fwd) || ptr >= IMG_MAX - 1) break;
         kept = (((p / CH) % n) == sel - 1);
         in_data  = kept ? img[ptr] : 8'hEE;
         in_valid = 1'b1;
         #1;
         acc = in_ready;
         if (out_valid && out_ready) begin
            if (out_data != img[pay_start + fwd]) fwd_bad = 1;
            fwd++;
         end
         @(posedge clk);
         if (acc) begin
            p++;
            if (kept) ptr++;
         end
      end
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
         end
      end
   end

   initial begin : main
      logic [54:0] v;
      int sel, n, scen;
      logic [7:0] tag;
      logic [2:0] ecode;
      logic [31:0] elen;
      bit ok;
      bit seen_stall, seen_drop;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: state after reset, no start yet
      in_valid = 1'b1;
      in_data  = 8'h00;
      #1;
      chk(found == 1'b0 && fail == 1'b0, "R10 status after reset", {found, fail}, 0);
      chk(fail_code == 3'd0, "R10 fail_code after reset", fail_code, 0);
      chk(in_ready == 1'b0 && out_valid == 1'b0, "R10 input blocked before start", {in_ready, out_valid}, 0);
      in_valid = 1'b0;

      for (int k = 0; k < 9; k++) begin
         v     = VECS[k];
         sel   = int'(v[54:51]);
         n     = int'(v[50:47]);
         tag   = v[46:39];
         scen  = int'(v[38:35]);
         ecode = v[34:32];
         elen  = v[31:0];
         ok    = (ecode == 3'd0);
         build(scen, tag);
         pulse_start(sel, n, tag);
         run_stream(sel, n, ok, 4);
         if (ok) begin
            chk(found == 1'b1 && fail == 1'b0, $sformatf("R1 found, vector %0d", k), {found, fail}, 2'b10);
            chk(sect_len == elen, $sformatf("R4 length, vector %0d", k), sect_len, elen);
            chk(!lat_bad, $sformatf("R8 found timing, vector %0d", k), lat_bad, 0);
            chk(!fwd_bad && fwd == 4, $sformatf("R9 forwarded bytes, vector %0d", k), fwd, 4);
         end else begin
            case (ecode)
               3'd1:    chk(fail && fail_code == ecode, $sformatf("R3 preamble code, vector %0d", k), {fail, fail_code}, {1'b1, ecode});
               3'd2:    chk(fail && fail_code == ecode, $sformatf("R5 tag code, vector %0d", k), {fail, fail_code}, {1'b1, ecode});
               3'd3:    chk(fail && fail_code == ecode, $sformatf("R6 length code, vector %0d", k), {fail, fail_code}, {1'b1, ecode});
               default: chk(fail && fail_code == ecode, $sformatf("R7 limit code, vector %0d", k), {fail, fail_code}, {1'b1, ecode});
            endcase
            // R11: terminal failure drains input and holds status
            in_data  = img[ptr];
            in_valid = 1'b1;
            #1;
            chk(in_ready == 1'b1 && out_valid == 1'b0, $sformatf("R11 drain, vector %0d", k), {in_ready, out_valid}, 2'b10);
            @(posedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            chk(fail && fail_code == ecode, $sformatf("R11 hold, vector %0d", k), fail_code, ecode);
         end
      end

      // R2 / R9: back-pressure touches only selected-image bytes after a match
      build(0, 8'h61);
      pulse_start(2, 2, 8'h61);
      run_stream(2, 2, 1'b1, 0);
      chk(found && sect_len == 32'd2, "R8 match on first section", sect_len, 2);
      out_ready = 1'b0;
      seen_stall = 0;
      seen_drop = 0;
      for (int g = 0; g < 3 * CH; g++) begin
         bit kept;
         kept = (((p / CH) % 2) == 1);
         @(negedge clk);
         in_data  = kept ? img[ptr] : 8'hEE;
         in_valid = 1'b1;
         out_ready = 1'b0;
         #1;
         if (kept && !seen_stall) begin
            chk(in_ready == 1'b0 && out_valid == 1'b1, "R9 kept byte stalls on out_ready low", {in_ready, out_valid}, 2'b01);
            seen_stall = 1;
         end
         if (!kept && !seen_drop) begin
            chk(in_ready == 1'b1 && out_valid == 1'b0, "R2 dropped byte flows on out_ready low", {in_ready, out_valid}, 2'b10);
            seen_drop = 1;
         end
         if (kept) out_ready = 1'b1;
         @(posedge clk);
         p++;
         if (kept) ptr++;
         if (seen_stall && seen_drop) break;
      end
      @(negedge clk);
      in_valid  = 1'b0;
      out_ready = 1'b1;
      chk(found && sect_len == 32'd2, "R8 status held while forwarding", sect_len, 2);

      // R1: a fresh start clears status
      pulse_start(1, 1, 8'h65);
      chk(!found && !fail && fail_code == 3'd0 && sect_len == 32'd0, "R1 start clears status",
          {found, fail, fail_code}, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule